// File: doc/BRIEF.md
# Timed Pulse Pattern Shutdown Detector

This block watches a single asynchronous control line and raises a shutdown request only when that line carries one specific timed pattern. At the block's pin the line rests high. A valid request drops the line low for one nominal period and returns it high for a second nominal period. The line then falls a final time and stays low. An inverting level shifter sits outside the block, so the logical request is the inverse of this pattern.

The line is synchronised and its edges are detected. A tick prescaler sets the resolution of a saturating interval counter, and that counter restarts on every edge. The length of the low pulse and the length of the high gap are each compared against an inclusive tolerance window around the nominal period. A saturated counter can never fall inside the window, so a long quiet stretch is never mistaken for a valid period, however long it lasts. Once raised, the shutdown flag holds until reset. A two-bit state vector is brought out for debug.

Top module: `shutdown_pattern_det`

## Requirements
- R1: While reset is held and in the first cycle after it, `shutdown_o` is 0 and `state_o` is 0. After reset the interval counter is preloaded with its saturated value.
- R2: A low pulse of 100 ticks followed by a high gap of 100 ticks and a final falling edge sets `shutdown_o` within 8 clock cycles of that final edge at the pin.
- R3: The low pulse is accepted only if its length, in ticks, lies between NOM_TICKS-TOL_TICKS and NOM_TICKS+TOL_TICKS inclusive. With defaults 89 and 111 are rejected and 90 and 110 are accepted.
- R4: The high gap is judged by the same inclusive window. A gap outside the window prevents shutdown even when the pulse was valid.
- R5: The interval counter saturates at SAT_TICKS (131) and stays there until the next edge. Any interval that reaches saturation is invalid, so long gaps never alias into a valid period.
- R6: A single falling edge with no later transitions never sets `shutdown_o`. `state_o` stays at 1.
- R7: `state_o` encodes 0 = armed (line high, waiting), 1 = pulse timing (line low), 2 = gap timing (line high), 3 = latched (line low). It advances by exactly one, modulo 4, on each detected edge and on nothing else.
- R8: After an invalid attempt ends in state 3, a rising edge returns the block to state 0. A following valid pattern then sets `shutdown_o`.
- R9: Once `shutdown_o` is set it stays set, whatever the line does, until reset.
- R10: Chatter made only of intervals shorter than the window never sets `shutdown_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Asynchronous control line, rests high at the pin |
| shutdown_o | output | 1 | Sticky shutdown request |
| state_o | output | 2 | Debug state vector (encoding in R7) |

## Verification
The assertions check on every cycle that the flag is sticky, and that the state only steps forward by one and only on an edge. They also check that the counter holds at saturation once it gets there, and that the flag can only rise as the machine passes from gap timing to latched. The bench scenarios are the only place where the window boundaries are exercised. They drive the 89/90/110/111-tick pulses and gaps, a pulse stretched by the counter's natural wrap length, a long quiet gap, a lone falling edge, recovery after a failed attempt and seeded random chatter. Each scenario is compared with the expected outcome computed from the tick lengths.

// File: rtl/shutdown_pattern_det_pkg.sv
package shutdown_pattern_det_pkg;
  typedef enum logic [1:0] {
    ST_ARMED   = 2'd0,
    ST_FIRST   = 2'd1,
    ST_SECOND  = 2'd2,
    ST_LATCHED = 2'd3
  } det_state_e;
endpackage

// File: rtl/line_sync_edge.sv
module line_sync_edge #(
  parameter int unsigned STAGES   = 2,
  parameter logic        IDLE_LVL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= IDLE_LVL;
        else         sync_q <= line_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= {STAGES{IDLE_LVL}};
        else         sync_q <= {sync_q[STAGES-2:0], line_i};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= IDLE_LVL;
    else         prev_q <= sync_q[STAGES-1];

  assign level_o = sync_q[STAGES-1];
  assign rise_o  = level_o & ~prev_q;
  assign fall_o  = ~level_o & prev_q;
endmodule

// File: rtl/tick_gen.sv
module tick_gen #(
  parameter int unsigned DIV = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int unsigned W = $clog2(DIV);
      localparam logic [W-1:0] LAST = W'(DIV - 1);
      logic [W-1:0] div_q;
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)            div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                    div_q <= div_q + 1'b1;
      assign tick_o = (div_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/interval_meter.sv
module interval_meter #(
  parameter int unsigned SAT_TICKS = 131,
  parameter int unsigned MIN_TICKS = 90,
  parameter int unsigned MAX_TICKS = 110,
  localparam int unsigned CNT_W    = $clog2(SAT_TICKS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             restart_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             in_win_o
);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(SAT_TICKS);
  localparam logic [CNT_W-1:0] LO  = CNT_W'(MIN_TICKS);
  localparam logic [CNT_W-1:0] HI  = CNT_W'(MAX_TICKS);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] meas;
  logic             sat;

  assign sat  = (cnt_q == SAT);
  // length including a tick landing on the closing edge
  assign meas = (sat || !tick_i) ? cnt_q : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)               cnt_q <= SAT;
    else if (restart_i)        cnt_q <= '0;
    else if (tick_i && !sat)   cnt_q <= cnt_q + 1'b1;

  assign in_win_o = (meas >= LO) && (meas <= HI) && (meas != SAT);
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/shutdown_pattern_det.sv
module shutdown_pattern_det
  import shutdown_pattern_det_pkg::*;
#(
  parameter int unsigned TICK_DIV    = 50000,
  parameter int unsigned NOM_TICKS   = 100,
  parameter int unsigned TOL_TICKS   = 10,
  parameter int unsigned SAT_TICKS   = 131,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned MIN_TICKS  = NOM_TICKS - TOL_TICKS,
  localparam int unsigned MAX_TICKS  = NOM_TICKS + TOL_TICKS,
  localparam int unsigned CNT_W      = $clog2(SAT_TICKS + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       line_i,
  output logic       shutdown_o,
  output logic [1:0] state_o
);
  logic             tick;
  logic             level;
  logic             edge_rise;
  logic             edge_fall;
  logic             edge_any;
  logic             in_win;
  logic [CNT_W-1:0] iv_cnt;

  det_state_e state_q;
  logic       first_ok_q;
  logic       shut_q;

  line_sync_edge #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (line_i),
    .level_o(level),
    .rise_o (edge_rise),
    .fall_o (edge_fall)
  );

  tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  assign edge_any = edge_rise | edge_fall;

  interval_meter #(
    .SAT_TICKS(SAT_TICKS),
    .MIN_TICKS(MIN_TICKS),
    .MAX_TICKS(MAX_TICKS)
  ) u_meter (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .restart_i(edge_any),
    .cnt_o    (iv_cnt),
    .in_win_o (in_win)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_ARMED;
      first_ok_q <= 1'b0;
      shut_q     <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ARMED: if (edge_fall) begin
          first_ok_q <= 1'b0;
          state_q    <= ST_FIRST;
        end
        ST_FIRST: if (edge_rise) begin
          first_ok_q <= in_win;
          state_q    <= ST_SECOND;
        end
        ST_SECOND: if (edge_fall) begin
          if (first_ok_q && in_win) shut_q <= 1'b1;
          state_q <= ST_LATCHED;
        end
        ST_LATCHED: if (edge_rise) begin
          first_ok_q <= 1'b0;
          state_q    <= ST_ARMED;
        end
        default: state_q <= ST_ARMED;
      endcase
    end
  end

  assign shutdown_o = shut_q;
  assign state_o    = state_q;

  logic unused_level;
  assign unused_level = level;
endmodule

// File: rtl/shutdown_pattern_det_chk.sv
module shutdown_pattern_det_chk #(
  parameter int unsigned SAT_TICKS = 131,
  parameter int unsigned CNT_W     = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             shutdown_o,
  input logic [1:0]       state_o,
  input logic             edge_rise,
  input logic             edge_fall,
  input logic [CNT_W-1:0] iv_cnt
);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(SAT_TICKS);

  // R1
  reset_state_chk: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (state_o == 2'd0) && !shutdown_o);

  // R9
  sticky_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shutdown_o |=> shutdown_o);

  // R2
  flag_on_final_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(shutdown_o) |-> (state_o == 2'd3) && ($past(state_o) == 2'd2));

  // R7
  state_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o != $past(state_o)) |-> (state_o == 2'($past(state_o) + 2'd1)));

  // R7
  state_needs_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(edge_rise || edge_fall) |=> $stable(state_o));

  // R7
  single_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({edge_rise, edge_fall}));

  // R5
  sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iv_cnt == SAT) && !(edge_rise || edge_fall) |=> (iv_cnt == SAT));

  // R5
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iv_cnt <= SAT);
endmodule

bind shutdown_pattern_det shutdown_pattern_det_chk #(
  .SAT_TICKS(SAT_TICKS),
  .CNT_W    (CNT_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .shutdown_o(shutdown_o),
  .state_o   (state_o),
  .edge_rise (edge_rise),
  .edge_fall (edge_fall),
  .iv_cnt    (iv_cnt)
);

// File: tb/shutdown_pattern_det_bench.sv
module shutdown_pattern_det_bench;
  localparam int DIV = 4;
  localparam int LO  = 90;
  localparam int HI  = 110;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line = 1'b1;
  logic       shut;
  logic [1:0] st;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  shutdown_pattern_det #(
    .TICK_DIV(DIV), .NOM_TICKS(100), .TOL_TICKS(10), .SAT_TICKS(131), .SYNC_STAGES(2)
  ) u_shutdown_pattern_det (
    .clk_i(clk), .rst_ni(rst_n), .line_i(line), .shutdown_o(shut), .state_o(st)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hold(input int units);
    repeat (units * DIV) @(negedge clk);
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic do_reset();
    line  = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  function automatic bit exp_shut(input int a, input int b);
    return (a >= LO) && (a <= HI) && (b >= LO) && (b <= HI);
  endfunction

  task automatic run_pat(input int a, input int b, input string req);
    do_reset();
    line = 1'b0; hold(a);
    line = 1'b1; hold(b);
    line = 1'b0; settle();
    chk(shut == exp_shut(a, b), req, int'(shut), int'(exp_shut(a, b)));
    chk(st == 2'd3, "R7", int'(st), 3);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int edges;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    // R1
    chk(shut == 1'b0, "R1", int'(shut), 0);
    chk(st == 2'd0, "R1", int'(st), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(st == 2'd0 && !shut, "R1", int'(st), 0);

    run_pat(100, 100, "R2");
    run_pat(89, 100, "R3");
    run_pat(90, 100, "R3");
    run_pat(110, 100, "R3");
    run_pat(111, 100, "R3");
    run_pat(100, 89, "R4");
    run_pat(100, 90, "R4");
    run_pat(100, 110, "R4");
    run_pat(100, 111, "R4");
    // R5: 100 + 256 would alias on an 8-bit wrapping counter
    run_pat(356, 100, "R5");
    run_pat(100, 1000, "R5");
    run_pat(131, 100, "R5");

    // R6 lone drop
    do_reset();
    line = 1'b0; hold(2000);
    chk(!shut, "R6", int'(shut), 0);
    chk(st == 2'd1, "R6", int'(st), 1);

    // R8 recovery after a failed attempt
    run_pat(80, 100, "R8");
    line = 1'b1; hold(20);
    chk(st == 2'd0, "R8", int'(st), 0);
    line = 1'b0; hold(100);
    line = 1'b1; hold(100);
    line = 1'b0; settle();
    chk(shut == 1'b1, "R8", int'(shut), 1);

    // R9 sticky under later activity
    for (int i = 0; i < 6; i++) begin
      line = ~line; hold(100);
    end
    chk(shut == 1'b1, "R9", int'(shut), 1);
    line = 1'b1; hold(5);
    chk(shut == 1'b1, "R9", int'(shut), 1);

    // R10 chatter with short intervals
    do_reset();
    edges = 0;
    for (int i = 0; i < 60; i++) begin
      line = ~line; edges++;
      hold(int'($urandom_range(1, 60)));
    end
    settle();
    chk(!shut, "R10", int'(shut), 0);
    chk(int'(st) == (edges % 4), "R7", int'(st), edges % 4);

    // random pulse/gap lengths around the window
    for (int i = 0; i < 24; i++) begin
      int a, b;
      a = int'($urandom_range(84, 116));
      b = int'($urandom_range(84, 116));
      run_pat(a, b, (i % 2 == 0) ? "R3" : "R4");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule